// File: doc/BRIEF.md
# Outbound Configuration Request Translator

This block sits in front of a root port and turns one configuration-space request (bus, device, function, register offset, read or write) into what the outbound path needs. That is a bus address, a transaction type code, and a packed target word naming the bus, device and function. Requests to bus 0 address the root's own register block directly. Every other bus goes through a fixed configuration aperture, which is the top 1 MB of a 16 MB outbound region. One programmable window (base, limit, target offset, enable) decides whether that aperture address is forwarded. On a forwarded access the target offset is added to the packed target word.

Device numbers that cannot exist downstream of a root port are filtered out. These are any device above 1 on bus 0 and any device above 0 on bus 1. Such a request is answered with an error at once. A rejected read also returns all-ones data, so a caller never sees stale bytes.

The block is a small state machine with five states:
- IDLE accepts a request.
- CHECK evaluates the captured request.
- CHECK moves to one of the three result states: REJECT (illegal device), LOCAL (bus 0) or REMOTE (any other legal request).
- Each result state presents the response for exactly one cycle and then returns to IDLE.

Top module: `cfgx_top`

## Requirements
- R1: `req_ready` is high only in IDLE. A request taken while `req_valid` and `req_ready` are both high yields exactly one cycle of `rsp_valid`, two clock edges after the accepting edge. `req_ready` is low during that time.
- R2: A request on bus 0 with device above 1, or on bus 1 with device above 0, gives `rsp_err`=1 with `rsp_addr`, `rsp_target` and `rsp_type` all zero, and `rsp_local`=`rsp_hit`=0.
- R3: A rejected read returns `rsp_rdata`=0xFFFFFFFF. A rejected write, and every accepted request, returns `rsp_rdata`=0.
- R4: An accepted request on bus 0 or 1 carries type code 4 (type 0 configuration). An accepted request on bus 2 or above carries type code 5 (type 1 configuration).
- R5: A legal bus 0 request sets `rsp_local`=1 and `rsp_hit`=0 whatever the window holds. Its `rsp_addr` is the local register base (default 0x01FFC000) plus the aligned offset.
- R6: A legal request on bus 1 or above gives `rsp_addr` = aperture base plus aligned offset. The aperture base is the region origin plus 15 MB, which is 0x01F00000 by default.
- R7: `rsp_target` packs the bus in bits [31:24], the device in [23:19] and the function in [18:16]. Bits [15:12] are zero and bits [11:0] hold the aligned offset. On a window hit the target offset register is added to this word, modulo 2^32.
- R8: The offset's two low bits are cleared in both `rsp_addr` and `rsp_target`.
- R9: Window registers are written while `cfg_we`=1, with `cfg_sel` choosing the register: 0 is base, 1 is limit, 2 is target offset, 3 is control. Only control bit 31 (enable) is stored. All window registers reset to zero.
- R10: `rsp_hit`=1 on a REMOTE response exactly when the enable bit is set and base ≤ `rsp_addr` ≤ limit, both bounds inclusive. Without a hit, `rsp_target` is the plain packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select |
| cfg_wdata | input | 32 | Window register write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Request rejected |
| rsp_local | output | 1 | Access to root's own registers |
| rsp_hit | output | 1 | Aperture address inside enabled window |
| rsp_type | output | 5 | Transaction type code |
| rsp_addr | output | 32 | Translated bus address |
| rsp_target | output | 32 | Packed target word |
| rsp_rdata | output | 32 | Read return for rejected reads |

## Verification
Three kinds of internal fault show up at the ports, and each shows on the response cycle of the request that meets it.
- A result state chosen wrongly is visible at once as the wrong one of `rsp_err`, `rsp_local` or `rsp_hit`.
- A stale capture register gives an address or target word that belongs to an earlier request.
- A state machine that fails to return to IDLE leaves `req_ready` low or repeats `rsp_valid` on the very next cycle.

Window boundary offsets and the filtered device edges (device 1 against 2 on bus 0, device 0 against 1 on bus 1) are driven on purpose, because off-by-one faults hide there.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int TYPE_W = 5;

    localparam logic [TYPE_W-1:0] TYPE_CFG0 = 5'd4;
    localparam logic [TYPE_W-1:0] TYPE_CFG1 = 5'd5;
    localparam logic [TYPE_W-1:0] TYPE_NONE = 5'd0;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_REJECT = 3'd2,
        ST_LOCAL  = 3'd3,
        ST_REMOTE = 3'd4
    } cfgx_state_e;

    localparam logic [1:0] SEL_BASE   = 2'd0;
    localparam logic [1:0] SEL_LIMIT  = 2'd1;
    localparam logic [1:0] SEL_TARGET = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

endpackage

// File: rtl/cfgx_filter.sv
module cfgx_filter
    import cfgx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    output logic              legal,
    output logic              is_local,
    output logic [TYPE_W-1:0] cfg_type
);
    // bus 0 hosts the root itself plus one slot; bus 1 has a single link partner
    localparam logic [DEV_W-1:0] MAX_DEV_BUS0 = DEV_W'(1);
    localparam logic [DEV_W-1:0] MAX_DEV_BUS1 = DEV_W'(0);

    logic on_bus0;
    logic on_bus1;

    always_comb begin
        on_bus0  = (bus == BUS_W'(0));
        on_bus1  = (bus == BUS_W'(1));
        legal    = 1'b1;
        if (on_bus0 && (dev > MAX_DEV_BUS0)) legal = 1'b0;
        if (on_bus1 && (dev > MAX_DEV_BUS1)) legal = 1'b0;
        is_local = on_bus0;
        cfg_type = (on_bus0 || on_bus1) ? TYPE_CFG0 : TYPE_CFG1;
    end

endmodule

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen #(
    parameter int          ADDR_W      = 32,
    parameter int          BUS_W       = 8,
    parameter int          DEV_W       = 5,
    parameter int          FN_W        = 3,
    parameter int          OFF_W       = 12,
    parameter logic [31:0] LOCAL_BASE  = 32'h01FF_C000,
    parameter logic [31:0] REGION_BASE = 32'h0100_0000,
    parameter logic [31:0] REGION_SIZE = 32'h0100_0000,
    parameter logic [31:0] APER_SIZE   = 32'h0010_0000
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] local_addr,
    output logic [ADDR_W-1:0] aper_addr,
    output logic [ADDR_W-1:0] packed_tgt
);
    localparam int BDF_W = BUS_W + DEV_W + FN_W;
    localparam int LOW_W = ADDR_W - BDF_W;
    localparam int PAD_W = LOW_W - OFF_W;
    localparam logic [ADDR_W-1:0] APER_BASE =
        ADDR_W'(REGION_BASE + REGION_SIZE - APER_SIZE);

    logic [OFF_W-1:0] off_al;
    logic [LOW_W-1:0] low_part;

    assign off_al = {off[OFF_W-1:2], 2'b00};

    generate
        if (PAD_W > 0) begin : g_pad
            assign low_part = {{PAD_W{1'b0}}, off_al};
        end else begin : g_nopad
            assign low_part = off_al[LOW_W-1:0];
        end
    endgenerate

    always_comb begin
        local_addr = ADDR_W'(LOCAL_BASE) + ADDR_W'(off_al);
        aper_addr  = APER_BASE + ADDR_W'(off_al);
        packed_tgt = {bus, dev, fn, low_part};
    end

endmodule

// File: rtl/cfgx_window.sv
module cfgx_window
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              win_hit,
    output logic [ADDR_W-1:0] win_target
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W-1:0] target_q;
    logic              enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            limit_q  <= '0;
            target_q <= '0;
            enable_q <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_BASE:   base_q   <= cfg_wdata;
                SEL_LIMIT:  limit_q  <= cfg_wdata;
                SEL_TARGET: target_q <= cfg_wdata;
                SEL_CTRL:   enable_q <= cfg_wdata[EN_BIT];
                default:    ;
            endcase
        end
    end

    always_comb begin
        win_hit    = enable_q && (probe_addr >= base_q) && (probe_addr <= limit_q);
        win_target = target_q;
    end

endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          BUS_W       = 8,
    parameter int          DEV_W       = 5,
    parameter int          FN_W        = 3,
    parameter int          OFF_W       = 12,
    parameter logic [31:0] LOCAL_BASE  = 32'h01FF_C000,
    parameter logic [31:0] REGION_BASE = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_local,
    output logic              rsp_hit,
    output logic [TYPE_W-1:0] rsp_type,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W-1:0] rsp_target,
    output logic [ADDR_W-1:0] rsp_rdata
);
    cfgx_state_e state_q, state_d;

    logic              wr_q;
    logic [BUS_W-1:0]  bus_q;
    logic [DEV_W-1:0]  dev_q;
    logic [FN_W-1:0]   fn_q;
    logic [OFF_W-1:0]  off_q;

    logic              legal;
    logic              is_local;
    logic [TYPE_W-1:0] cfg_type;
    logic [ADDR_W-1:0] local_addr;
    logic [ADDR_W-1:0] aper_addr;
    logic [ADDR_W-1:0] packed_tgt;
    logic              win_hit;
    logic [ADDR_W-1:0] win_target;
    logic              take;

    assign take = req_valid && (state_q == ST_IDLE);

    cfgx_filter #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_filter (
        .bus      (bus_q),
        .dev      (dev_q),
        .legal    (legal),
        .is_local (is_local),
        .cfg_type (cfg_type)
    );

    cfgx_addr_gen #(
        .ADDR_W      (ADDR_W),
        .BUS_W       (BUS_W),
        .DEV_W       (DEV_W),
        .FN_W        (FN_W),
        .OFF_W       (OFF_W),
        .LOCAL_BASE  (LOCAL_BASE),
        .REGION_BASE (REGION_BASE)
    ) u_addr (
        .bus        (bus_q),
        .dev        (dev_q),
        .fn         (fn_q),
        .off        (off_q),
        .local_addr (local_addr),
        .aper_addr  (aper_addr),
        .packed_tgt (packed_tgt)
    );

    cfgx_window #(.ADDR_W(ADDR_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .probe_addr (aper_addr),
        .win_hit    (win_hit),
        .win_target (win_target)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            bus_q <= '0;
            dev_q <= '0;
            fn_q  <= '0;
            off_q <= '0;
        end else if (take) begin
            wr_q  <= req_write;
            bus_q <= req_bus;
            dev_q <= req_dev;
            fn_q  <= req_fn;
            off_q <= req_off;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!legal)        state_d = ST_REJECT;
                else if (is_local) state_d = ST_LOCAL;
                else               state_d = ST_REMOTE;
            end
            ST_REJECT: state_d = ST_IDLE;
            ST_LOCAL:  state_d = ST_IDLE;
            ST_REMOTE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        rsp_local  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_type   = TYPE_NONE;
        rsp_addr   = '0;
        rsp_target = '0;
        rsp_rdata  = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_CHECK: ;
            ST_REJECT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                rsp_rdata = wr_q ? '0 : '1;
            end
            ST_LOCAL: begin
                rsp_valid  = 1'b1;
                rsp_local  = 1'b1;
                rsp_type   = cfg_type;
                rsp_addr   = local_addr;
                rsp_target = packed_tgt;
            end
            ST_REMOTE: begin
                rsp_valid  = 1'b1;
                rsp_hit    = win_hit;
                rsp_type   = cfg_type;
                rsp_addr   = aper_addr;
                rsp_target = win_hit ? (packed_tgt + win_target) : packed_tgt;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic        rsp_local,
    input logic        rsp_hit,
    input logic [4:0]  rsp_type,
    input logic [31:0] rsp_addr,
    input logic [31:0] rsp_target,
    input logic [31:0] rsp_rdata
);
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid, 2) && $past(req_ready, 2))); // R1
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_REJECT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_addr == 32'h0 && rsp_target == 32'h0 && rsp_type == 5'd0)); // R2
    AST_REJECT_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !$past(req_write, 2)) |-> (rsp_rdata == 32'hFFFF_FFFF)); // R3
    AST_TYPE_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && !rsp_hit) |->
            (rsp_type == ((rsp_target[31:24] < 8'd2) ? 5'd4 : 5'd5))); // R4
    AST_LOCAL_BUS0: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_local |-> (rsp_target[31:24] == 8'd0 && !rsp_hit)); // R5
    AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_err, rsp_local, rsp_hit})); // R2
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr[1:0] == 2'b00)); // R8
endmodule

bind cfgx_top cfgx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_local  (rsp_local),
    .rsp_hit    (rsp_hit),
    .rsp_type   (rsp_type),
    .rsp_addr   (rsp_addr),
    .rsp_target (rsp_target),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/sim_cfgx_top.sv
`timescale 1ns/1ps
module sim_cfgx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_local, rsp_hit;
    logic [4:0]  rsp_type;
    logic [31:0] rsp_addr, rsp_target, rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench view of the window registers
    logic [31:0] m_base = '0, m_limit = '0, m_tgt = '0;
    bit          m_en = 1'b0;

    always #4 clk = ~clk;

    cfgx_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
        .req_off(req_off), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_local(rsp_local), .rsp_hit(rsp_hit),
        .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_target(rsp_target), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_legal(input logic [7:0] b, input logic [4:0] d);
        if (b == 8'd0 && d > 5'd1) return 1'b0;
        if (b == 8'd1 && d > 5'd0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_base = val;
            2'd1: m_limit = val;
            2'd2: m_tgt = val;
            default: m_en = val[31];
        endcase
    endtask

    task automatic do_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                          input logic [11:0] o, input bit w);
        logic [31:0] e_addr, e_tgt, e_rd, pk;
        logic [4:0]  e_type;
        bit          e_err, e_loc, e_hit;
        @(negedge clk);
        chk("R1 ready in idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_bus = b; req_dev = d; req_fn = f; req_off = o; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        req_bus = $urandom; req_dev = $urandom; req_off = $urandom;
        chk("R1 busy no ready", {30'b0, req_ready, rsp_valid}, 32'd0);
        // model
        pk     = {b, d, f, 4'h0, o[11:2], 2'b00};
        e_err  = !f_legal(b, d);
        e_loc  = !e_err && (b == 8'd0);
        e_addr = e_err ? 32'h0 : e_loc ? (32'h01FF_C000 + {o[11:2], 2'b00})
                                       : (32'h01F0_0000 + {o[11:2], 2'b00});
        e_hit  = !e_err && !e_loc && m_en && e_addr >= m_base && e_addr <= m_limit;
        e_tgt  = e_err ? 32'h0 : e_hit ? pk + m_tgt : pk;
        e_type = e_err ? 5'd0 : (b < 8'd2) ? 5'd4 : 5'd5;
        e_rd   = (e_err && !w) ? 32'hFFFF_FFFF : 32'h0;
        @(negedge clk);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R2 err flag", {31'b0, rsp_err}, {31'b0, e_err});
        chk("R3 rdata", rsp_rdata, e_rd);
        chk("R4 type", {27'b0, rsp_type}, {27'b0, e_type});
        chk("R5 local", {31'b0, rsp_local}, {31'b0, e_loc});
        chk("R6 R8 addr", rsp_addr, e_addr);
        chk("R7 target", rsp_target, e_tgt);
        chk("R10 hit", {31'b0, rsp_hit}, {31'b0, e_hit});
        @(negedge clk);
        chk("R1 single pulse", {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R1 reset no rsp", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // R9 window disabled after reset: no hit even at base 0..0
        do_req(8'd2, 5'd3, 3'd1, 12'h000, 1'b0);
        // R2 R3 filter edges
        do_req(8'd0, 5'd1, 3'd0, 12'h010, 1'b0);
        do_req(8'd0, 5'd2, 3'd0, 12'h010, 1'b0);
        do_req(8'd0, 5'd2, 3'd0, 12'h010, 1'b1);
        do_req(8'd1, 5'd0, 3'd7, 12'hFFF, 1'b0);
        do_req(8'd1, 5'd1, 3'd0, 12'h004, 1'b0);
        // R8 misaligned offsets
        do_req(8'd0, 5'd0, 3'd0, 12'h007, 1'b0);
        do_req(8'd5, 5'd31, 3'd7, 12'h3FB, 1'b1);
        // R9 R10 window boundaries
        wr_cfg(2'd0, 32'h01F0_0100);
        wr_cfg(2'd1, 32'h01F0_0200);
        wr_cfg(2'd2, 32'h0000_1000);
        do_req(8'd3, 5'd0, 3'd0, 12'h100, 1'b0); // R9 enable still clear
        wr_cfg(2'd3, 32'h8000_0000);
        do_req(8'd3, 5'd0, 3'd0, 12'h0FC, 1'b0);
        do_req(8'd3, 5'd0, 3'd0, 12'h100, 1'b0);
        do_req(8'd3, 5'd0, 3'd0, 12'h200, 1'b0);
        do_req(8'd3, 5'd0, 3'd0, 12'h204, 1'b0);
        do_req(8'd1, 5'd0, 3'd2, 12'h180, 1'b1);
        do_req(8'd0, 5'd1, 3'd0, 12'h180, 1'b0); // R5 local ignores window
        wr_cfg(2'd3, 32'h7FFF_FFFF);
        do_req(8'd3, 5'd0, 3'd0, 12'h150, 1'b0); // R9 bit31 clear disables
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] b;
            int sel;
            if (i % 50 == 0) begin
                wr_cfg(2'd0, 32'h01F0_0000 + ($urandom % 32'h1000));
                wr_cfg(2'd1, m_base + ($urandom % 32'h800));
                wr_cfg(2'd2, $urandom);
                wr_cfg(2'd3, $urandom);
            end
            sel = $urandom % 4;
            b = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 : (sel == 2) ? 8'd2 : 8'($urandom);
            do_req(b, ($urandom % 2) ? 5'($urandom % 3) : 5'($urandom),
                   3'($urandom), 12'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule